// File: doc/BRIEF.md
# Peripheral Access Timeout Supervisor

This block watches every cycle that a host bridge issues to one of several peripheral module slots. When a cycle starts, the block records which slot is addressed and starts a cycle counter. If the module acknowledges before the counter reaches its limit, the block completes the host cycle with the data the module returned. If the limit is reached first, the block completes the host cycle itself so the host bus is never held. The completion carries a fill value of all ones. The block then sets a sticky bus-error bit for the slot that was addressed.

Software clears each error bit by writing a 1 to it. Each bit has its own interrupt enable, and the interrupt output is raised while any enabled error bit is set. Because each slot has its own bit, software can probe for a fitted module by reading its location and then inspecting that slot's bit. Other threads' slots are unaffected. Address decoding and data steering are done outside this block.

The control is a three-state machine. `ST_IDLE` waits for a start. Transition START goes to `ST_WAIT` on `cyc_start`. In `ST_WAIT`, transition ACK goes to `ST_RESP` when `mod_ack` is seen. Transition EXPIRE goes to `ST_RESP` when the limit is reached without an acknowledge. `ST_RESP` drives the one-cycle completion, and transition RETURN goes back to `ST_IDLE` unconditionally.

Top module: `slot_timeout_guard`

## Requirements
- R1: After reset, `host_done` is 0, every `err_status` bit is 0 and `irq` is 0.
- R2: If `cyc_start` is sampled at edge 0 and `mod_ack` is first sampled at edge k, with 1 <= k <= TIMEOUT_CYCLES, then `host_done` is high for exactly the cycle after edge k. In that cycle `host_rdata` equals the `mod_rdata` sampled at edge k, and `err_status` is unchanged.
- R3: If no `mod_ack` is sampled at edges 1 to TIMEOUT_CYCLES, the block completes the cycle itself. `host_done` is then high for exactly the cycle after edge TIMEOUT_CYCLES.
- R4: A completion forced by timeout presents `host_rdata` as all ones.
- R5: A timeout sets `err_status[s]`, where s is the `cyc_slot` value (binary slot number, bit s of the status vector) sampled with `cyc_start`. It changes no other bit, and the bit stays set until cleared.
- R6: A 1 in bit i of `err_clear` at an edge clears `err_status[i]`, and a 0 leaves the bit unchanged. If a timeout sets the same bit at the same edge, the set wins.
- R7: `irq` equals the OR over all slots of `err_status[i] AND irq_enable[i]`, combinationally and at all times.
- R8: If `mod_ack` is sampled at the same edge at which the limit is reached, the acknowledge wins. The completion carries the module data and no error bit is set.
- R9: `cyc_start` is ignored while a cycle is outstanding, and the slot of the outstanding cycle is kept. `mod_ack` is ignored while no cycle is outstanding.
- R10: Each accepted start yields exactly one single-cycle `host_done`. The counter restarts from zero for every access, so each access gets the full limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-cycle pulse: a slot cycle begins |
| cyc_slot | input | SLOT_W | Slot number of the starting cycle |
| mod_ack | input | 1 | Module acknowledge |
| mod_rdata | input | DATA_W | Data returned by the module with its acknowledge |
| host_done | output | 1 | One-cycle completion toward the host |
| host_rdata | output | DATA_W | Completion data (module data, or all ones on timeout) |
| err_clear | input | NUM_SLOTS | Write-one-to-clear strobe for the error bits |
| irq_enable | input | NUM_SLOTS | Per-slot interrupt enables |
| err_status | output | NUM_SLOTS | Sticky per-slot bus-error bits |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the completion is a single pulse and never follows an idle cycle;
- an acknowledge in the waiting state always beats expiry and carries its data;
- an expiry always yields the all-ones fill;
- an error bit rises only through its own set pulse, holds until cleared, and clears on a strobe;
- the counter stays in range and restarts;
- the held slot stays stable while busy.

The bench sweeps every slot against every acknowledge position, from the first edge through the limit edge and beyond it. This sweep is the only way to show the exact completion cycle and the coincident-acknowledge case end to end. The bench also covers the set-versus-clear collision, the ignored start and acknowledge, and the interrupt output under all sixteen enable patterns.

// File: rtl/slot_guard_pkg.sv
package slot_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } guard_state_e;

endpackage

// File: rtl/guard_timer.sv
module guard_timer #(
    parameter int TIMEOUT_CYCLES = 234
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && (cnt_q == LAST);

    // R3: the counter never passes the limit value
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R10: every access starts counting from zero
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
    import slot_guard_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int DATA_W    = 32,
    parameter int SLOT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cyc_start,
    input  logic [SLOT_W-1:0]    cyc_slot,
    input  logic                 mod_ack,
    input  logic [DATA_W-1:0]    mod_rdata,
    input  logic                 expire,
    output logic                 timer_restart,
    output logic                 timer_run,
    output logic [NUM_SLOTS-1:0] err_set,
    output logic                 host_done,
    output logic [DATA_W-1:0]    host_rdata
);
    guard_state_e state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [DATA_W-1:0] rdata_q;
    logic              fire;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cyc_start)          state_d = ST_WAIT;  // START
            ST_WAIT: if (mod_ack || expire)  state_d = ST_RESP;  // ACK / EXPIRE
            ST_RESP:                         state_d = ST_IDLE;  // RETURN
            default:                         state_d = ST_IDLE;
        endcase
    end

    // captured slot and completion data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && cyc_start) slot_q <= cyc_slot;
            if (state_q == ST_WAIT) begin
                if (mod_ack)     rdata_q <= mod_rdata;
                else if (expire) rdata_q <= {DATA_W{1'b1}};
            end
        end
    end

    // outputs
    always_comb begin
        timer_restart = (state_q != ST_WAIT);
        timer_run     = (state_q == ST_WAIT);
        fire          = (state_q == ST_WAIT) && expire && !mod_ack;
        host_done     = (state_q == ST_RESP);
        host_rdata    = rdata_q;
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_set
        assign err_set[i] = fire && (slot_q == SLOT_W'(i));
    end

    // R10: completion lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    // R9: an idle cycle is never followed by a completion
    p_idle_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !host_done);

    // R9: slot held while a cycle is outstanding
    p_slot_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(slot_q));

    // R8: acknowledge beats expiry and carries module data
    p_ack_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && mod_ack) |=>
            (host_done && host_rdata == $past(mod_rdata)));

    // R4: forced completion returns the fill value
    p_expire_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && expire && !mod_ack) |=>
            (host_done && host_rdata == {DATA_W{1'b1}}));

endmodule

// File: rtl/guard_status.sv
module guard_status #(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] err_set,
    input  logic [NUM_SLOTS-1:0] err_clear,
    input  logic [NUM_SLOTS-1:0] irq_enable,
    output logic [NUM_SLOTS-1:0] err_status,
    output logic                 irq
);
    logic [NUM_SLOTS-1:0] status_q;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)          status_q[i] <= 1'b0;
            else if (err_set[i]) status_q[i] <= 1'b1;
            else if (err_clear[i]) status_q[i] <= 1'b0;
        end

        // R5: a set pulse leaves the bit set
        p_set_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
            err_set[i] |=> status_q[i]);

        // R5: a bit rises only through its own set pulse
        p_no_stray_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!status_q[i] && !err_set[i]) |=> !status_q[i]);

        // R6: strobe clears the bit
        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[i] && err_clear[i] && !err_set[i]) |=> !status_q[i]);

        // R6: without a strobe the bit holds
        p_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[i] && !err_clear[i]) |=> status_q[i]);
    end

    assign err_status = status_q;
    assign irq        = |(status_q & irq_enable);

endmodule

// File: rtl/slot_timeout_guard.sv
module slot_timeout_guard #(
    parameter int NUM_SLOTS      = 4,
    parameter int DATA_W         = 32,
    parameter int TIMEOUT_CYCLES = 234,
    localparam int SLOT_W        = (NUM_SLOTS > 2) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cyc_start,
    input  logic [SLOT_W-1:0]    cyc_slot,
    input  logic                 mod_ack,
    input  logic [DATA_W-1:0]    mod_rdata,
    output logic                 host_done,
    output logic [DATA_W-1:0]    host_rdata,
    input  logic [NUM_SLOTS-1:0] err_clear,
    input  logic [NUM_SLOTS-1:0] irq_enable,
    output logic [NUM_SLOTS-1:0] err_status,
    output logic                 irq
);
    logic                 timer_restart;
    logic                 timer_run;
    logic                 expire;
    logic [NUM_SLOTS-1:0] err_set;

    guard_timer #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .run     (timer_run),
        .expire  (expire)
    );

    guard_fsm #(
        .NUM_SLOTS (NUM_SLOTS),
        .DATA_W    (DATA_W),
        .SLOT_W    (SLOT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cyc_start     (cyc_start),
        .cyc_slot      (cyc_slot),
        .mod_ack       (mod_ack),
        .mod_rdata     (mod_rdata),
        .expire        (expire),
        .timer_restart (timer_restart),
        .timer_run     (timer_run),
        .err_set       (err_set),
        .host_done     (host_done),
        .host_rdata    (host_rdata)
    );

    guard_status #(
        .NUM_SLOTS(NUM_SLOTS)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_set    (err_set),
        .err_clear  (err_clear),
        .irq_enable (irq_enable),
        .err_status (err_status),
        .irq        (irq)
    );

endmodule

// File: tb/slot_timeout_guard_bench.sv
module slot_timeout_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LIM        = 8;
    localparam int NS         = 4;
    localparam int DW         = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cyc_start;
    logic [1:0]    cyc_slot;
    logic          mod_ack;
    logic [DW-1:0] mod_rdata;
    logic          host_done;
    logic [DW-1:0] host_rdata;
    logic [NS-1:0] err_clear;
    logic [NS-1:0] irq_enable;
    logic [NS-1:0] err_status;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [NS-1:0] status_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_timeout_guard #(
        .NUM_SLOTS(NS), .DATA_W(DW), .TIMEOUT_CYCLES(LIM)
    ) u_slot_timeout_guard (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_slot(cyc_slot),
        .mod_ack(mod_ack), .mod_rdata(mod_rdata), .host_done(host_done),
        .host_rdata(host_rdata), .err_clear(err_clear), .irq_enable(irq_enable),
        .err_status(err_status), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access: start at edge 0, ack at edge ack_at (> LIM means none),
    // optional clear strobe at edge clr_at, optional busy start at edge 2.
    task automatic run_access(input int slot, input int ack_at, input logic [DW-1:0] data,
                              input int clr_at, input logic [NS-1:0] clr_mask,
                              input bit busy_start);
        int done_edge = 0;
        int done_cnt  = 0;
        logic [DW-1:0] got = '0;
        bit timed_out = (ack_at > LIM);
        int exp_edge  = timed_out ? LIM : ack_at;
        logic [DW-1:0] exp_data = timed_out ? {DW{1'b1}} : data;
        logic [NS-1:0] applied = (clr_at >= 1 && clr_at <= LIM + 2) ? clr_mask : '0;
        logic [NS-1:0] setbit = timed_out ? NS'(1 << slot) : '0;
        @(negedge clk);
        cyc_start = 1'b1;
        cyc_slot  = 2'(slot);
        @(negedge clk);
        cyc_start = 1'b0;
        for (int e = 1; e <= LIM + 2; e++) begin
            mod_ack   = (e == ack_at);
            mod_rdata = data;
            err_clear = (e == clr_at) ? clr_mask : '0;
            if (busy_start && e == 2) begin
                cyc_start = 1'b1;
                cyc_slot  = 2'((slot + 1) % NS);
            end
            @(negedge clk);
            mod_ack   = 1'b0;
            err_clear = '0;
            cyc_start = 1'b0;
            if (host_done) begin
                done_cnt++;
                if (done_edge == 0) begin
                    done_edge = e;
                    got = host_rdata;
                end
            end
        end
        status_m = (status_m & ~applied) | setbit;
        // R2/R3/R8: completion edge; R10: single completion
        check(done_edge == exp_edge, timed_out ? "R3 completion edge" : "R2/R8 completion edge",
              done_edge, exp_edge);
        check(done_cnt == 1, "R10 one completion", done_cnt, 1);
        // R2 module data, R4 fill value
        check(got == exp_data, timed_out ? "R4 fill data" : "R2 module data", got, exp_data);
        // R5/R6/R9 status after the access
        check(err_status == status_m, "R5/R6/R9 status", err_status, status_m);
    endtask

    task automatic irq_sweep();
        for (int en = 0; en < 16; en++) begin
            @(negedge clk);
            irq_enable = 4'(en);
            #1;
            // R7: irq is OR of status AND enable
            check(irq == |(status_m & 4'(en)), "R7 irq", irq, |(status_m & 4'(en)));
        end
        irq_enable = '0;
    endtask

    task automatic clear_bits(input logic [NS-1:0] m);
        @(negedge clk);
        err_clear = m;
        @(negedge clk);
        err_clear = '0;
        status_m = status_m & ~m;
        // R6 clear by writing ones, zeros leave bits alone
        check(err_status == status_m, "R6 clear", err_status, status_m);
    endtask

    initial begin
        rst_n = 1'b0; cyc_start = 1'b0; cyc_slot = '0; mod_ack = 1'b0;
        mod_rdata = '0; err_clear = '0; irq_enable = '1;
        status_m = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(host_done == 1'b0, "R1 done", host_done, 0);
        check(err_status == '0, "R1 status", err_status, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        rst_n = 1'b1;
        irq_enable = '0;

        // Sweep every acknowledge position against every slot
        for (int a = 1; a <= LIM + 1; a++) begin
            for (int s = 0; s < NS; s++) begin
                run_access(s, a, 32'hA500_0000 + 32'(a * 16 + s), 0, '0, 1'b0);
            end
            irq_sweep();
            clear_bits(4'b0101);
            clear_bits(4'b1010);
        end

        // R9: ack while idle is ignored
        @(negedge clk);
        mod_ack = 1'b1; mod_rdata = 32'h1234_5678;
        @(negedge clk);
        mod_ack = 1'b0;
        check(host_done == 1'b0, "R9 idle ack", host_done, 0);
        @(negedge clk);
        check(host_done == 1'b0, "R9 idle ack later", host_done, 0);

        // R9: start while busy ignored; original slot gets the error
        run_access(1, LIM + 1, '0, 0, '0, 1'b1);
        @(negedge clk);
        check(host_done == 1'b0, "R9 no extra completion", host_done, 0);
        check(err_status == 4'b0010, "R9 busy slot kept", err_status, 4'b0010);

        // R6: set and clear of the same bit at the same edge, set wins
        run_access(1, LIM + 1, '0, LIM, 4'b0010, 1'b0);
        // R6: clear of another bit during an access, R5 sticky bit untouched
        run_access(3, LIM + 1, '0, 3, 4'b0010, 1'b0);
        // R10: back-to-back timeouts each get the full limit
        run_access(0, LIM + 1, '0, 0, '0, 1'b0);
        run_access(0, LIM, 32'hCAFE_F00D, 0, '0, 1'b0);
        irq_sweep();
        clear_bits(4'b1111);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule